// File: doc/BRIEF.md
# Reset Preamplifier Recovery Controller

This block sits on the digitized sample stream of one channel fed by a reset-type charge preamplifier. The preamplifier integrates charge into a rising (or falling) staircase. When it discharges, it produces a step that is far larger than any detector pulse and that runs against the pulse direction. The block compares each sample with the one before it and flags a reset when the step against the pulse direction exceeds a programmable threshold.

On a detected reset it starts two timed windows together. A fast time-constant output tells the analog front end to switch its differentiator to its short setting, so that the discharge transient dies out quickly. An inhibit output tells downstream event processing to ignore the channel while the preamplifier settles. When the fast window ends, the block issues a single-cycle clear to the digital shaping filters, so they restart from the recovered baseline. A reset that arrives while the windows are open restarts both of them. A saturating counter of detected resets lets dead time be accounted for. One sample is taken on every clock.

Top module: `preamp_reset_guard`

## Requirements
- R1: The step is `prev - cur` when `neg_pulses_i` is 0 (positive-going pulses) and `cur - prev` when it is 1. Both are computed as signed values one bit wider than the sample. A reset is detected only when the step is strictly greater than the unsigned `step_thresh_i`, so a step of any size in the pulse direction is never detected.
- R2: The first sample taken after reset release has no predecessor and never causes a detection, whatever value was present before reset.
- R3: A detection is registered at the rising edge that samples the jumped value. `fast_tc_o` rises at the next edge and stays high for L clocks, where L is `fast_tc_len_i`, and a value of 0 selects the parameter default of 160.
- R4: `filter_clear_o` is high for exactly one clock, in the clock right after `fast_tc_o` falls. It is never high while `fast_tc_o` is high.
- R5: `inhibit_o` rises on the same edge as `fast_tc_o` and stays high for `inhibit_len_i` clocks, where a value of 0 is treated as 1.
- R6: A detection while either window is open reloads both windows to their full length from the new detection. If the reload falls on the clock where the fast window would have expired, that window continues without a gap and no clear is issued for it.
- R7: `reset_count_o` increases by one on the edge where `fast_tc_o` is started by a detection. It holds its value otherwise and saturates at 2^CNT_W-1.
- R8: While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one sample per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_i | input | SAMPLE_W | Signed preamplifier sample |
| neg_pulses_i | input | 1 | 1 when detector pulses are negative-going |
| step_thresh_i | input | SAMPLE_W | Unsigned step size that a reset must exceed |
| fast_tc_len_i | input | WIN_W | Fast time-constant window in clocks, 0 selects the default |
| inhibit_len_i | input | WIN_W | Inhibit window in clocks, 0 acts as 1 |
| fast_tc_o | output | 1 | Short differentiation time-constant request |
| filter_clear_o | output | 1 | One-clock clear for the digital filters |
| inhibit_o | output | 1 | Event processing disable |
| reset_count_o | output | CNT_W | Saturating count of detected resets |

## Verification
A jumped sample shows up on `fast_tc_o`, `inhibit_o` and `reset_count_o` two rising edges after it is driven: one edge registers the detection and the next starts the windows. The clear appears on the edge after the fast window closes. The bench keeps a reference model that advances on each rising edge from the inputs alone, and it compares every output with that model on the falling edge, where all of these latencies have settled. Directed sequences count high cycles over a whole episode to pin down window lengths, the restart cases and the clear count, and they read the counter several edges after the last jump.

// File: rtl/rg_pkg.sv
// Shared helpers for the reset preamplifier recovery controller.
// Assumes configuration lengths fit in 32 bits.
package rg_pkg;

    // Substitute a fallback when a programmed length is zero.
    function automatic logic [31:0] len_or(input logic [31:0] len,
                                           input logic [31:0] fallback);
        return (len == 32'd0) ? fallback : len;
    endfunction

endpackage

// File: rtl/rg_step_detect.sv
// Step detector: compares each sample with the one before it and flags a
// step against the pulse direction that exceeds the threshold.
// Assumes one valid sample per clock. The result is registered, so hit_o
// describes the sample taken on the previous edge.
module rg_step_detect #(
    parameter int SAMPLE_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic signed [SAMPLE_W-1:0] sample_i,
    input  logic                       neg_pulses_i,
    input  logic        [SAMPLE_W-1:0] thresh_i,
    output logic                       hit_o
);
    localparam int DW = SAMPLE_W + 1;

    logic signed [SAMPLE_W-1:0] prev_q;
    logic                       have_prev_q;
    logic signed [DW-1:0]       cur_x, prev_x, rise, step, thr_x;
    logic                       over;

    // Widen operands and form the step against the pulse direction.
    always_comb begin
        cur_x  = {sample_i[SAMPLE_W-1], sample_i};
        prev_x = {prev_q[SAMPLE_W-1], prev_q};
        rise   = cur_x - prev_x;
        step   = neg_pulses_i ? rise : -rise;
        thr_x  = {1'b0, thresh_i};
        over   = have_prev_q && (step > thr_x);
    end

    // Keep the previous sample and register the comparison result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q      <= '0;
            have_prev_q <= 1'b0;
            hit_o       <= 1'b0;
        end else begin
            prev_q      <= sample_i;
            have_prev_q <= 1'b1;
            hit_o       <= over;
        end
    end

    // A sample with no predecessor cannot produce a detection.
    assert_first_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !have_prev_q |=> !hit_o);

    // A detection requires that a previous sample existed one edge earlier.
    assert_hit_has_prev_R1: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> $past(have_prev_q));

endmodule

// File: rtl/rg_window_timer.sv
// Retriggerable window timer: active_o goes high on the edge after start_i
// and stays high for len_i clocks. A new start reloads the full length.
// With END_PULSE set, end_o pulses for one clock after a natural expiry.
// Assumes len_i >= 1.
module rg_window_timer #(
    parameter int LEN_W     = 16,
    parameter bit END_PULSE = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [LEN_W-1:0] len_i,
    output logic             active_o,
    output logic             end_o
);
    logic [LEN_W-1:0] rem_q;
    logic             expire;

    assign expire = active_o && !start_i && (rem_q == '0);

    // Load, count down and close the window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_o <= 1'b0;
            rem_q    <= '0;
        end else if (start_i) begin
            active_o <= 1'b1;
            rem_q    <= len_i - 1'b1;
        end else if (active_o) begin
            if (rem_q == '0) active_o <= 1'b0;
            else             rem_q    <= rem_q - 1'b1;
        end
    end

    generate
        if (END_PULSE) begin : g_end
            logic end_q;
            // Flag the clock right after a natural expiry.
            always_ff @(posedge clk) begin
                if (!rst_n) end_q <= 1'b0;
                else        end_q <= expire;
            end
            assign end_o = end_q;
        end else begin : g_no_end
            assign end_o = 1'b0;
        end
    endgenerate

    assert_start_opens_R6: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> active_o);

    assert_end_follows_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        end_o |-> (!active_o && $past(active_o)));

    assert_end_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        end_o |=> !end_o);

endmodule

// File: rtl/rg_sat_counter.sv
// Saturating event counter: counts inc_i pulses and sticks at all ones.
module rg_sat_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc_i,
    output logic [W-1:0] count_o
);
    localparam logic [W-1:0] TOP = '1;

    // Increment unless already at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n)                       count_o <= '0;
        else if (inc_i && count_o != TOP) count_o <= count_o + 1'b1;
    end

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !inc_i |=> $stable(count_o));

    assert_saturate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o == TOP) |=> (count_o == TOP));

    assert_step_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && count_o != TOP) |=> (count_o == $past(count_o) + 1'b1));

endmodule

// File: rtl/preamp_reset_guard.sv
// Reset preamplifier recovery controller: detects the discharge step of a
// reset preamplifier and sequences the fast time-constant request, the
// filter clear at its end, a programmable inhibit and a reset count.
// Assumes one sample per clock; configuration is read when a window starts.
module preamp_reset_guard #(
    parameter int          SAMPLE_W        = 16,
    parameter int          WIN_W           = 16,
    parameter int          CNT_W           = 8,
    parameter int unsigned DEFAULT_FAST_TC = 160
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic signed [SAMPLE_W-1:0] sample_i,
    input  logic                       neg_pulses_i,
    input  logic        [SAMPLE_W-1:0] step_thresh_i,
    input  logic        [WIN_W-1:0]    fast_tc_len_i,
    input  logic        [WIN_W-1:0]    inhibit_len_i,
    output logic                       fast_tc_o,
    output logic                       filter_clear_o,
    output logic                       inhibit_o,
    output logic        [CNT_W-1:0]    reset_count_o
);
    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    logic             hit;
    logic             inh_end;
    logic [WIN_W-1:0] fast_len;
    logic [WIN_W-1:0] inh_len;

    // Resolve zero-valued lengths to their defined substitutes.
    always_comb begin
        fast_len = WIN_W'(rg_pkg::len_or(32'(fast_tc_len_i), 32'(DEFAULT_FAST_TC)));
        inh_len  = WIN_W'(rg_pkg::len_or(32'(inhibit_len_i), 32'd1));
    end

    rg_step_detect #(.SAMPLE_W(SAMPLE_W)) u_detect (
        .clk          (clk),
        .rst_n        (rst_n),
        .sample_i     (sample_i),
        .neg_pulses_i (neg_pulses_i),
        .thresh_i     (step_thresh_i),
        .hit_o        (hit)
    );

    rg_window_timer #(.LEN_W(WIN_W), .END_PULSE(1'b1)) u_fast_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (hit),
        .len_i    (fast_len),
        .active_o (fast_tc_o),
        .end_o    (filter_clear_o)
    );

    rg_window_timer #(.LEN_W(WIN_W), .END_PULSE(1'b1)) u_inh_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (hit),
        .len_i    (inh_len),
        .active_o (inhibit_o),
        .end_o    (inh_end)
    );

    rg_sat_counter #(.W(CNT_W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_i   (hit),
        .count_o (reset_count_o)
    );

    assert_windows_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (fast_tc_o && inhibit_o));

    assert_clear_after_fast_R4: assert property (@(posedge clk) disable iff (!rst_n)
        filter_clear_o |-> ($past(fast_tc_o) && !fast_tc_o));

    assert_inhibit_closed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        inh_end |-> !inhibit_o);

    assert_count_moves_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (reset_count_o != $past(reset_count_o) || reset_count_o == CNT_TOP));

    // Outputs are quiet on the edge after a reset cycle.
    always_ff @(posedge clk) begin
        if ($past(!rst_n) && !$isunknown($past(rst_n)))
            assert_reset_quiet_R8: assert (!fast_tc_o && !filter_clear_o &&
                                           !inhibit_o && reset_count_o == '0);
    end

endmodule

// File: tb/preamp_reset_guard_bench.sv
module preamp_reset_guard_bench;
    localparam int SW   = 16;
    localparam int WW   = 16;
    localparam int CW   = 8;
    localparam int DEF  = 160;
    localparam int CMAX = (1 << CW) - 1;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic signed [SW-1:0] sample = '0;
    logic                 neg_pol = 1'b0;
    logic [SW-1:0]        thr = 16'd1000;
    logic [WW-1:0]        fast_len = 16'd20;
    logic [WW-1:0]        inh_len = 16'd30;
    logic                 fast_tc_o, filter_clear_o, inhibit_o;
    logic [CW-1:0]        reset_count_o;

    int checks = 0;
    int failures = 0;
    bit run_checks = 1'b0;
    bit finished = 1'b0;

    // reference model state
    int m_prev = 0;
    bit m_valid = 1'b0;
    bit m_hit = 1'b0;
    int m_fast_left = 0;
    int m_inh_left = 0;
    bit m_clear = 1'b0;
    int m_count = 0;

    always #10 clk = ~clk;

    preamp_reset_guard #(.SAMPLE_W(SW), .WIN_W(WW), .CNT_W(CW), .DEFAULT_FAST_TC(DEF))
    u_preamp_reset_guard (
        .clk(clk), .rst_n(rst_n), .sample_i(sample), .neg_pulses_i(neg_pol),
        .step_thresh_i(thr), .fast_tc_len_i(fast_len), .inhibit_len_i(inh_len),
        .fast_tc_o(fast_tc_o), .filter_clear_o(filter_clear_o),
        .inhibit_o(inhibit_o), .reset_count_o(reset_count_o)
    );

    // Reference model built from the requirements, advanced each rising edge.
    always @(posedge clk) begin : ref_model
        int cur, stp, flen, ilen;
        bit nh;
        if (!rst_n) begin
            m_prev = 0; m_valid = 1'b0; m_hit = 1'b0;
            m_fast_left = 0; m_inh_left = 0; m_clear = 1'b0; m_count = 0;
        end else begin
            cur  = int'(sample);
            stp  = neg_pol ? (cur - m_prev) : (m_prev - cur);
            nh   = m_valid && (stp > int'(thr));
            flen = (fast_len == 0) ? DEF : int'(fast_len);
            ilen = (inh_len == 0) ? 1 : int'(inh_len);
            if (m_hit) begin
                m_fast_left = flen;
                m_inh_left  = ilen;
                m_clear     = 1'b0;
                if (m_count < CMAX) m_count++;
            end else begin
                m_clear = (m_fast_left == 1);
                if (m_fast_left > 0) m_fast_left--;
                if (m_inh_left > 0)  m_inh_left--;
            end
            m_hit   = nh;
            m_prev  = cur;
            m_valid = 1'b1;
        end
    end

    task automatic check_eq(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Compare every output with the model away from the active edge.
    always @(negedge clk) begin
        if (rst_n && run_checks && !finished) begin
            check_eq("R3", "fast_tc_o vs model", int'(fast_tc_o), (m_fast_left > 0) ? 1 : 0);
            check_eq("R4", "filter_clear_o vs model", int'(filter_clear_o), m_clear ? 1 : 0);
            check_eq("R5", "inhibit_o vs model", int'(inhibit_o), (m_inh_left > 0) ? 1 : 0);
            check_eq("R7", "reset_count_o vs model", int'(reset_count_o), m_count);
        end
    end

    task automatic set_cfg(input bit pol, input int t, input int fl, input int il);
        neg_pol  = pol;
        thr      = SW'(t);
        fast_len = WW'(fl);
        inh_len  = WW'(il);
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Move the sample upward (ignored with positive pulses) and let it settle.
    task automatic rearm();
        @(negedge clk);
        sample = SW'(10000);
        settle(2);
    endtask

    // Drop the sample by 3000, optionally again at negedge jump2_at, and count outputs.
    task automatic measure(input int n, input int jump2_at,
                           output int f, output int inh, output int clr);
        f = 0; inh = 0; clr = 0;
        @(negedge clk);
        sample = SW'(int'(sample) - 3000);
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            f   += int'(fast_tc_o);
            inh += int'(inhibit_o);
            clr += int'(filter_clear_o);
            if (i == jump2_at) sample = SW'(int'(sample) - 3000);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        int f, inh, clr, base, delta;
        void'($urandom(32'd13579));

        // R8: reset state
        sample = SW'(5000);
        rst_n  = 1'b0;
        settle(3);
        check_eq("R8", "fast_tc_o in reset", int'(fast_tc_o), 0);
        check_eq("R8", "filter_clear_o in reset", int'(filter_clear_o), 0);
        check_eq("R8", "inhibit_o in reset", int'(inhibit_o), 0);
        check_eq("R8", "reset_count_o in reset", int'(reset_count_o), 0);

        // R2: large change across reset release is not a detection
        @(negedge clk);
        sample = -SW'(5000);
        rst_n = 1'b1;
        run_checks = 1'b1;
        settle(4);
        check_eq("R2", "count after first sample", int'(reset_count_o), 0);
        check_eq("R2", "fast_tc_o after first sample", int'(fast_tc_o), 0);

        // R1: direction and strict threshold, positive pulses
        @(negedge clk); sample = SW'(0);        // +5000 step, pulse direction
        settle(4);
        check_eq("R1", "step in pulse direction", int'(reset_count_o), 0);
        @(negedge clk); sample = -SW'(1000);    // step equal to threshold
        settle(4);
        check_eq("R1", "step equal to threshold", int'(reset_count_o), 0);
        @(negedge clk); sample = -SW'(2001);    // step 1001
        settle(3);
        check_eq("R1", "step above threshold", int'(reset_count_o), 1);
        settle(40);

        // R1: negative pulses, reset steps go upward
        set_cfg(1'b1, 1000, 20, 30);
        @(negedge clk); sample = -SW'(9000);    // downward 6999, pulse direction
        settle(4);
        check_eq("R1", "negative pulses ignore downward step", int'(reset_count_o), 1);
        @(negedge clk); sample = -SW'(7500);    // upward 1500
        settle(3);
        check_eq("R1", "negative pulses detect upward step", int'(reset_count_o), 2);
        settle(40);

        // R3 default length, R5 long inhibit, R4 single clear
        set_cfg(1'b0, 1000, 0, 200);
        rearm();
        measure(260, -1, f, inh, clr);
        check_eq("R3", "default fast window length", f, DEF);
        check_eq("R5", "inhibit window length 200", inh, 200);
        check_eq("R4", "one clear per window", clr, 1);

        // R5: zero inhibit acts as one clock
        set_cfg(1'b0, 1000, 5, 0);
        rearm();
        measure(40, -1, f, inh, clr);
        check_eq("R3", "programmed fast window 5", f, 5);
        check_eq("R5", "zero inhibit length", inh, 1);
        check_eq("R4", "clear after short window", clr, 1);

        // R6: restart in the middle of the windows
        set_cfg(1'b0, 1000, 20, 30);
        rearm();
        measure(80, 10, f, inh, clr);
        check_eq("R6", "fast window restarted mid-way", f, 30);
        check_eq("R6", "inhibit restarted mid-way", inh, 40);
        check_eq("R6", "single clear after restart", clr, 1);

        // R6: restart on the expiry clock leaves no gap and no early clear
        rearm();
        measure(80, 20, f, inh, clr);
        check_eq("R6", "restart at expiry fast length", f, 40);
        check_eq("R6", "restart at expiry clear count", clr, 1);

        // R6 contrast: one clock later the first window closes with its clear
        rearm();
        measure(80, 21, f, inh, clr);
        check_eq("R6", "restart after expiry fast length", f, 40);
        check_eq("R6", "restart after expiry clear count", clr, 2);

        // Random stimulus checked against the model (R1 R3 R4 R5 R6 R7)
        base = int'(sample);
        for (int blk = 0; blk < 30; blk++) begin
            @(negedge clk);
            set_cfg(1'($urandom_range(0, 1)), int'($urandom_range(200, 3000)),
                    ($urandom_range(0, 7) == 0) ? 0 : int'($urandom_range(1, 40)),
                    int'($urandom_range(0, 80)));
            for (int c = 0; c < 200; c++) begin
                @(negedge clk);
                if ($urandom_range(0, 29) == 0)
                    delta = ($urandom_range(0, 1) == 1) ? int'($urandom_range(0, 5000))
                                                       : -int'($urandom_range(0, 5000));
                else
                    delta = int'($urandom_range(0, 100)) - 50;
                base += delta;
                if (base > 20000)  base = 20000;
                if (base < -20000) base = -20000;
                sample = SW'(base);
            end
        end
        settle(200);

        // R7: saturation
        set_cfg(1'b0, 100, 1, 1);
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            sample = (i % 2 == 1) ? -SW'(500) : SW'(0);
        end
        settle(4);
        check_eq("R7", "counter saturated", int'(reset_count_o), CMAX);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            sample = (i % 2 == 1) ? -SW'(500) : SW'(0);
        end
        settle(4);
        check_eq("R7", "counter stays saturated", int'(reset_count_o), CMAX);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule